// File: doc/BRIEF.md
# Hysteretic Four-Speed Fan Controller

This block picks one of four fan speeds from a heatsink temperature given in whole degrees Celsius. In automatic operation each pair of neighbouring speeds has its own rising and falling threshold. The falling point of each pair sits 3 to 4 °C below its rising point, so a temperature that wanders near one threshold does not make the fan hunt between two speeds.

The temperature arrives with a one-cycle valid strobe. A mode input either leaves the choice to the temperature tracker or forces one of the four speeds. The result is a 2-bit speed code for the fan drive stage. Each sample can move the automatic speed by no more than one step. A sample far outside the current band therefore takes several samples to reach its final speed.

Top module: `fan_speed_ctrl`

## Requirements
- R1: After reset `speed_o` is SLOW. The speed codes are SLOW=0, FAST=1, FASTER=2 and FASTEST=3.
- R2: In automatic mode at SLOW, a valid sample of 37 °C or more moves the speed to FAST. `speed_o` shows the new speed after the clock edge that captures the sample. A sample below 37 leaves it at SLOW.
- R3: In automatic mode a valid sample of 43 °C or more moves FAST to FASTER. A valid sample of 48 °C or more moves FASTER to FASTEST.
- R4: In automatic mode a valid sample of 34 °C or less moves FAST to SLOW. A sample of 39 °C or less moves FASTER to FAST, and a sample of 44 °C or less moves FASTEST to FASTER.
- R5: A valid sample that lies strictly between the falling and rising thresholds of the current speed leaves the speed unchanged. For example, FAST holds for 35 to 42 °C.
- R6: A single valid sample changes the automatic speed by at most one step. This holds even when the sample lies beyond several thresholds.
- R7: While `temp_vld_i` is low the automatic speed holds, whatever value `temp_i` carries.
- R8: The 3-bit `mode_i` value 0 selects automatic control. Values 1, 2, 3 and 4 force SLOW, FAST, FASTER and FASTEST, and `speed_o` follows `mode_i` in the same cycle. In these fixed modes temperature samples have no effect on `speed_o`.
- R9: `mode_i` values 5, 6 and 7 behave exactly like value 0, which is automatic control.
- R10: The automatic tracker is held at SLOW while a fixed mode is selected. On entering automatic mode `speed_o` is SLOW, and it then follows the thresholds from the next sample on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| temp_i | input | TEMP_W (8) | Heatsink temperature in °C, unsigned integer |
| temp_vld_i | input | 1 | High for one cycle per temperature sample |
| mode_i | input | 3 | 0 or 5-7 = automatic, 1-4 = fixed SLOW..FASTEST |
| speed_o | output | 2 | Selected fan speed code |

## Verification
On every cycle the assertions check four properties. The automatic speed never jumps two steps. It holds when no sample is valid. A fixed mode keeps the output steady. A step up and a step down are never requested together. They also confirm that entering automatic mode shows SLOW and that a sample below the first rising point leaves SLOW alone. The exact threshold values, both edges of each hysteresis band, the mapping of every mode code, and the fact that fixed-mode samples leave the tracker untouched can only be shown by the bench's directed temperature sequences.

// File: rtl/fan_pkg.sv
package fan_pkg;

  typedef enum logic [1:0] {
    SPD_SLOW    = 2'd0,
    SPD_FAST    = 2'd1,
    SPD_FASTER  = 2'd2,
    SPD_FASTEST = 2'd3
  } speed_t;

  localparam int NUM_SPEEDS = 4;
  localparam int NSTEP      = NUM_SPEEDS - 1;
  localparam int MODE_W     = 3;

  // Fixed modes are the codes 1..NUM_SPEEDS; every other code means automatic.
  function automatic logic mode_is_fixed(input logic [MODE_W-1:0] m);
    return (m >= MODE_W'(1)) && (m <= MODE_W'(NUM_SPEEDS));
  endfunction

  function automatic speed_t mode_to_speed(input logic [MODE_W-1:0] m);
    logic [MODE_W-1:0] d;
    d = m - MODE_W'(1);
    return speed_t'(d[1:0]);
  endfunction

  // Rising request for the pair above the current speed.
  function automatic logic want_up(input speed_t s, input logic [NSTEP-1:0] up);
    case (s)
      SPD_SLOW:   return up[0];
      SPD_FAST:   return up[1];
      SPD_FASTER: return up[2];
      default:    return 1'b0;
    endcase
  endfunction

  // Falling request for the pair below the current speed.
  function automatic logic want_down(input speed_t s, input logic [NSTEP-1:0] dn);
    case (s)
      SPD_FAST:    return dn[0];
      SPD_FASTER:  return dn[1];
      SPD_FASTEST: return dn[2];
      default:     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fan_thr_cmp.sv
module fan_thr_cmp
  import fan_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int UP_THR [NSTEP] = '{37, 43, 48},
  parameter int DN_THR [NSTEP] = '{34, 39, 44}
) (
  input  logic [TEMP_W-1:0] temp_i,
  output logic [NSTEP-1:0]  up_hit,
  output logic [NSTEP-1:0]  dn_hit
);

  for (genvar k = 0; k < NSTEP; k++) begin : g_pair
    assign up_hit[k] = (temp_i >= TEMP_W'(UP_THR[k]));
    assign dn_hit[k] = (temp_i <= TEMP_W'(DN_THR[k]));
  end

endmodule

// File: rtl/fan_auto_track.sv
module fan_auto_track
  import fan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sample_vld,
  input  logic [NSTEP-1:0] up_hit,
  input  logic [NSTEP-1:0] dn_hit,
  output speed_t           speed_q,
  output logic             step_up,
  output logic             step_dn
);

  assign step_up = want_up(speed_q, up_hit);
  assign step_dn = want_down(speed_q, dn_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      speed_q <= SPD_SLOW;
    else if (!enable)
      speed_q <= SPD_SLOW;
    else if (sample_vld && step_up)
      speed_q <= speed_t'(speed_q + 2'd1);
    else if (sample_vld && step_dn)
      speed_q <= speed_t'(speed_q - 2'd1);
  end

endmodule

// File: rtl/fan_speed_ctrl.sv
module fan_speed_ctrl
  import fan_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int UP_THR [NSTEP] = '{37, 43, 48},
  parameter int DN_THR [NSTEP] = '{34, 39, 44}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              temp_vld_i,
  input  logic [2:0]        mode_i,
  output logic [1:0]        speed_o
);

  logic [NSTEP-1:0] up_hit;
  logic [NSTEP-1:0] dn_hit;
  logic             in_auto;
  logic             step_up;
  logic             step_dn;
  speed_t           auto_q;

  assign in_auto = !mode_is_fixed(mode_i);

  fan_thr_cmp #(
    .TEMP_W (TEMP_W),
    .UP_THR (UP_THR),
    .DN_THR (DN_THR)
  ) u_cmp (
    .temp_i (temp_i),
    .up_hit (up_hit),
    .dn_hit (dn_hit)
  );

  fan_auto_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (in_auto),
    .sample_vld (temp_vld_i),
    .up_hit     (up_hit),
    .dn_hit     (dn_hit),
    .speed_q    (auto_q),
    .step_up    (step_up),
    .step_dn    (step_dn)
  );

  assign speed_o = in_auto ? auto_q : mode_to_speed(mode_i);

endmodule

// File: rtl/fan_speed_ctrl_chk.sv
module fan_speed_ctrl_chk #(
  parameter int TEMP_W = 8,
  parameter int FIRST_UP = 37
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TEMP_W-1:0] temp_i,
  input logic              temp_vld_i,
  input logic [2:0]        mode_i,
  input logic              in_auto,
  input logic              step_up,
  input logic              step_dn,
  input logic [1:0]        auto_q,
  input logic [1:0]        speed_o
);

  // R6: never two steps in one edge while tracking
  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_auto |=> ((auto_q - $past(auto_q)) != 2'd2));

  // R7: no sample, no movement
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_auto && !temp_vld_i) |=> $stable(auto_q));

  // R8: a fixed mode held steady keeps the output steady
  p_fixed_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_auto |=> ((mode_i != $past(mode_i)) || $stable(speed_o)));

  // R5: threshold ordering never asks for both directions
  p_no_conflict_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));

  // R10: entering automatic control shows SLOW
  p_auto_entry_slow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_auto) |-> (speed_o == 2'd0));

  // R2: below the first rising point SLOW is kept
  p_below_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_auto && temp_vld_i && auto_q == 2'd0 && temp_i < TEMP_W'(FIRST_UP))
      |=> (auto_q == 2'd0));

endmodule

bind fan_speed_ctrl fan_speed_ctrl_chk #(
  .TEMP_W   (TEMP_W),
  .FIRST_UP (UP_THR[0])
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .temp_i     (temp_i),
  .temp_vld_i (temp_vld_i),
  .mode_i     (mode_i),
  .in_auto    (in_auto),
  .step_up    (step_up),
  .step_dn    (step_dn),
  .auto_q     (auto_q),
  .speed_o    (speed_o)
);

// File: tb/fan_speed_ctrl_tb.sv
module fan_speed_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] temp_i = '0;
  logic       temp_vld_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic [1:0] speed_o;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fan_speed_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .temp_i     (temp_i),
    .temp_vld_i (temp_vld_i),
    .mode_i     (mode_i),
    .speed_o    (speed_o)
  );

  task automatic check(input string req, input logic [1:0] exp);
    n_run++;
    if (speed_o !== exp) begin
      n_fail++;
      $display("FAIL %s: speed_o=%0d expected %0d", req, speed_o, exp);
    end
  endtask

  // one valid sample; the speed is checked on the following falling edge
  task automatic sample(input int t, input string req, input logic [1:0] exp);
    @(negedge clk);
    temp_i = 8'(t);
    temp_vld_i = 1'b1;
    @(negedge clk);
    temp_vld_i = 1'b0;
    check(req, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mode_i = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", 2'd0);
  endtask

  task automatic t_rise();
    sample(36, "R2 below 37", 2'd0);
    sample(37, "R2 at 37", 2'd1);
    sample(42, "R5 band FAST", 2'd1);
    sample(43, "R3 at 43", 2'd2);
    sample(47, "R5 band FASTER", 2'd2);
    sample(48, "R3 at 48", 2'd3);
    sample(120, "R3 stays FASTEST", 2'd3);
  endtask

  task automatic t_fall();
    sample(45, "R5 FASTEST holds at 45", 2'd3);
    sample(44, "R4 at 44", 2'd2);
    sample(40, "R5 FASTER holds at 40", 2'd2);
    sample(39, "R4 at 39", 2'd1);
    sample(35, "R5 FAST holds at 35", 2'd1);
    sample(34, "R4 at 34", 2'd0);
    sample(0, "R4 SLOW floor", 2'd0);
  endtask

  task automatic t_single_step();
    sample(90, "R6 up 1", 2'd1);
    sample(90, "R6 up 2", 2'd2);
    sample(90, "R6 up 3", 2'd3);
    sample(5, "R6 down 1", 2'd2);
    sample(5, "R6 down 2", 2'd1);
    sample(5, "R6 down 3", 2'd0);
  endtask

  task automatic t_idle();
    sample(40, "R7 setup", 2'd1);
    @(negedge clk);
    temp_i = 8'd100;
    repeat (5) @(negedge clk);
    check("R7 hold high temp", 2'd1);
    temp_i = 8'd0;
    repeat (5) @(negedge clk);
    check("R7 hold low temp", 2'd1);
  endtask

  task automatic t_fixed();
    // tracker is at FAST here
    for (int m = 1; m <= 4; m++) begin
      @(negedge clk);
      mode_i = 3'(m);
      @(negedge clk);
      check("R8 fixed code", 2'(m - 1));
      sample(100, "R8 ignores hot", 2'(m - 1));
      sample(0, "R8 ignores cold", 2'(m - 1));
    end
    sample(100, "R8 FASTEST fixed hot", 2'd3);
    @(negedge clk);
    mode_i = 3'd0;
    @(negedge clk);
    check("R10 entry SLOW", 2'd0);
    sample(40, "R10 follows after entry", 2'd1);
  endtask

  task automatic t_alias();
    @(negedge clk);
    mode_i = 3'd2;
    @(negedge clk);
    mode_i = 3'd5;
    @(negedge clk);
    check("R9 code5 auto entry", 2'd0);
    sample(37, "R9 code5 tracks", 2'd1);
    mode_i = 3'd6;
    sample(43, "R9 code6 tracks", 2'd2);
    mode_i = 3'd7;
    sample(48, "R9 code7 tracks", 2'd3);
    sample(44, "R9 code7 falls", 2'd2);
    mode_i = 3'd0;
  endtask

  initial begin
    do_reset();
    t_rise();
    t_fall();
    t_single_step();
    t_idle();
    t_fixed();
    t_alias();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule